// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a cycle-accurate, synthesizable behavioural model of a quad-data-rate SRAM. It has one shared address bus, one write data port and one read data port. Every command moves a fixed burst of four words. Both data ports carry one word per beat, and there are two beats in each input clock (K) period. The model is clocked by a beat clock `clk`. A phase output, `kPhase`, shows which rising edges of `clk` stand for rising edges of K: `kPhase` low means the next edge is a K edge. The other edges stand for the complementary half of K. The first edge after reset is a K edge.

A read command and a write command contend for the address bus on each K edge. A command that is accepted holds its port for two K periods. Write beats go into the array one by one as they are captured. Read words leave through a registered output stage that floats the data bus whenever no word is being driven. An echo clock pair toggles on every beat and stays in phase with the read words.

Top module: `qdrBurstSram`

## Requirements
- R1: A burst covers four words at the base address, which is the command address with its two low bits forced to 0. Word k of the burst uses address base + k, for k = 0 to 3, in that order.
- R2: A read is accepted when `readN` is 0 at a K edge n and no read is pending. Its word k is driven with `rdOe` = 1 from edge n+3+k.
- R3: A command arriving at the K edge right after an accepted command of the same type (read after read, write after write) is ignored.
- R4: Reads accepted at K edges n and n+4 give eight consecutive beats with `rdOe` = 1, from edge n+3 to edge n+10.
- R5: At the edge after the last word of a burst, if no further burst follows, `rdOe` goes to 0 and `rdData` is released to high impedance.
- R6: A write is accepted when `writeN` is 0 at a K edge n. Its data word k is captured from `wrData` at edge n+2+k.
- R7: In each beat, bit b of `byteWrN` is active low and gates byte lane b, which is `wrData[8b+7:8b]`. Lanes whose bit is 1 keep their old content.
- R8: When a read and a write are both eligible at the same K edge, the read takes the address and the write is ignored.
- R9: A read word reflects every write beat to its address captured at an earlier edge, including beats of a write burst that is still in progress.
- R10: `echoN` is always the complement of `echoP`. `echoP` toggles on every edge, and it is 1 during any beat that carries word 0 or word 2 of a burst.
- R11: After reset, `rdOe` is 0, `echoP` is 1, `echoN` is 0, `kPhase` is 0 and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges per K period |
| rstN | input | 1 | Asynchronous active-low reset |
| readN | input | 1 | Active-low read command, sampled on K edges |
| writeN | input | 1 | Active-low write command, sampled on K edges |
| addr | input | ADDR_W | Shared read/write address |
| wrData | input | N_BYTES*BYTE_W | Write data beat |
| byteWrN | input | N_BYTES | Active-low byte-lane write enables for the beat |
| rdData | output | N_BYTES*BYTE_W | Read data beat; high impedance when idle |
| rdOe | output | 1 | High while `rdData` drives a read word |
| echoP | output | 1 | Echo clock, true phase |
| echoN | output | 1 | Echo clock, complement phase |
| kPhase | output | 1 | Low when the next `clk` edge is a K edge |

## Verification
The embedded assertions check the following on every cycle:
- the echo pair stays complementary and keeps toggling;
- a pending read or write slot never survives a K edge, so a second command of the same type cannot be latched;
- a write hand-over never collides with a write burst still in progress;
- the first beat of every read burst falls on an echo-high beat.

Only the directed scenarios can show that the data itself is right. These scenarios cover:
- the burst address order, including a base address with nonzero low bits;
- byte-lane merging;
- which command loses in a same-edge collision;
- that an ignored command left memory untouched;
- the exact beat on which output starts and stops;
- that a read overlapping a write burst returns the new data.

// File: rtl/qdrPkg.sv
package qdrPkg;
  // Strobes issued by the sequencer to the storage/output datapath.
  typedef struct packed {
    logic wrEn;    // commit one write beat this edge
    logic rdLoad;  // load one read word into the output stage this edge
  } ctrlStrb_t;
endpackage

// File: rtl/qdrCtrl.sv
module qdrCtrl
  import qdrPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              phase
);
  localparam int HI_W = ADDR_W - 2;

  logic            kEdge;
  logic            rdPend, rdAct, wrPend, wrAct;
  logic [HI_W-1:0] rdPendBase, rdBase, wrPendBase, wrBase;
  logic [1:0]      rdIdx, wrIdx;
  logic            rdAccept, wrAccept, rdXfer, wrXfer;

  assign kEdge    = ~phase;
  assign rdAccept = kEdge & ~readN & ~rdPend;
  // Read owns the shared address bus when both are eligible.
  assign wrAccept = kEdge & ~writeN & ~wrPend & ~rdAccept;
  assign rdXfer   = kEdge & rdPend;
  assign wrXfer   = kEdge & wrPend;

  assign strb.rdLoad = rdAct;
  assign strb.wrEn   = wrXfer | wrAct;
  assign rdAddr      = {rdBase, rdIdx};
  assign wrAddr      = wrXfer ? {wrPendBase, 2'b00} : {wrBase, wrIdx};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= 1'b0;
      rdPend     <= 1'b0;
      rdPendBase <= '0;
      rdAct      <= 1'b0;
      rdIdx      <= '0;
      rdBase     <= '0;
      wrPend     <= 1'b0;
      wrPendBase <= '0;
      wrAct      <= 1'b0;
      wrIdx      <= '0;
      wrBase     <= '0;
    end else begin
      phase <= ~phase;

      if (rdAccept) begin
        rdPend     <= 1'b1;
        rdPendBase <= addr[ADDR_W-1:2];
      end else if (rdXfer) begin
        rdPend <= 1'b0;
      end

      if (rdXfer) begin
        rdAct  <= 1'b1;
        rdIdx  <= 2'd0;
        rdBase <= rdPendBase;
      end else if (rdAct) begin
        rdIdx <= rdIdx + 2'd1;
        if (rdIdx == 2'd3) rdAct <= 1'b0;
      end

      if (wrAccept) begin
        wrPend     <= 1'b1;
        wrPendBase <= addr[ADDR_W-1:2];
      end else if (wrXfer) begin
        wrPend <= 1'b0;
      end

      if (wrXfer) begin
        wrAct  <= 1'b1;
        wrIdx  <= 2'd1;
        wrBase <= wrPendBase;
      end else if (wrAct) begin
        wrIdx <= wrIdx + 2'd1;
        if (wrIdx == 2'd3) wrAct <= 1'b0;
      end
    end
  end

  // R3: a pending read slot is always handed over at the next K edge.
  p_rd_no_relatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (kEdge && rdPend) |=> !rdPend);
  // R3: the same holds for the write slot.
  p_wr_no_relatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (kEdge && wrPend) |=> !wrPend);
  // R6: a new write burst never starts while beats of the previous one remain.
  p_wr_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(kEdge && wrPend && wrAct));
endmodule

// File: rtl/qdrData.sv
module qdrData
  import qdrPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrb_t                 strb,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [N_BYTES*BYTE_W-1:0] wrData,
  input  logic [N_BYTES-1:0]        byteWrN,
  output logic [N_BYTES*BYTE_W-1:0] qData,
  output logic                      qValid,
  output logic                      echoP,
  output logic                      echoN
);
  localparam int DW    = N_BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] memRd;

  for (genvar g = 0; g < N_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int a = 0; a < DEPTH; a++) laneMem[a] <= '0;
      end else if (strb.wrEn && !byteWrN[g]) begin
        laneMem[wrAddr] <= wrData[g*BYTE_W +: BYTE_W];
      end
    end

    assign memRd[g*BYTE_W +: BYTE_W] = laneMem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qData  <= '0;
      qValid <= 1'b0;
      echoP  <= 1'b1;
      echoN  <= 1'b0;
    end else begin
      qValid <= strb.rdLoad;
      if (strb.rdLoad) qData <= memRd;
      echoP <= ~echoP;
      echoN <= ~echoN;
    end
  end

  // R10: the echo pair stays complementary.
  p_echo_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    echoN != echoP);
  // R10: the echo clock runs freely, one toggle per beat.
  p_echo_toggle_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (echoP != $past(echoP)));
endmodule

// File: rtl/qdrBurstSram.sv
module qdrBurstSram
  import qdrPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      readN,
  input  logic                      writeN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_BYTES*BYTE_W-1:0] wrData,
  input  logic [N_BYTES-1:0]        byteWrN,
  output wire  [N_BYTES*BYTE_W-1:0] rdData,
  output logic                      rdOe,
  output logic                      echoP,
  output logic                      echoN,
  output logic                      kPhase
);
  localparam int DW = N_BYTES * BYTE_W;

  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [DW-1:0]     qData;
  logic              qValid, phase;

  qdrCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .readN(readN), .writeN(writeN), .addr(addr),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .phase(phase)
  );

  qdrData #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .byteWrN(byteWrN), .qData(qData), .qValid(qValid),
    .echoP(echoP), .echoN(echoN)
  );

  assign rdOe   = qValid;
  assign rdData = qValid ? qData : {DW{1'bz}};
  assign kPhase = phase;

  // R10: a burst's first beat always rides an echo-high beat.
  p_first_word_echo_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdOe) |-> echoP);
endmodule

// File: tb/qdrBurstSram_test.sv
module qdrBurstSram_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 6;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 2;
  localparam int DW      = N_BYTES * BYTE_W;
  localparam int SEQ     = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readN = 1'b1, writeN = 1'b1;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DW-1:0]      wrData = '0;
  logic [N_BYTES-1:0] byteWrN = '1;
  wire  [DW-1:0]      rdData;
  logic rdOe, echoP, echoN, kPhase;

  int nTests = 0;
  int nFail  = 0;

  // per-edge stimulus and per-edge samples (index i = state around edge i)
  logic               cmdR [SEQ];
  logic               cmdW [SEQ];
  logic [ADDR_W-1:0]  sA   [SEQ];
  logic [DW-1:0]      sD   [SEQ];
  logic [N_BYTES-1:0] sM   [SEQ];
  logic               oV   [SEQ];
  logic [DW-1:0]      oQ   [SEQ];
  logic               oE   [SEQ];
  logic               oN   [SEQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  qdrBurstSram #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) uut (
    .clk(clk), .rstN(rstN), .readN(readN), .writeN(writeN), .addr(addr),
    .wrData(wrData), .byteWrN(byteWrN), .rdData(rdData), .rdOe(rdOe),
    .echoP(echoP), .echoN(echoN), .kPhase(kPhase)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearSeq();
    for (int i = 0; i < SEQ; i++) begin
      cmdR[i] = 1'b0; cmdW[i] = 1'b0; sA[i] = '0; sD[i] = '0; sM[i] = '1;
    end
  endtask

  task automatic runSeq(input int len);
    @(negedge clk);
    while (kPhase !== 1'b0) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      readN = ~cmdR[i]; writeN = ~cmdW[i];
      addr = sA[i]; wrData = sD[i]; byteWrN = sM[i];
      @(negedge clk);
      oV[i] = rdOe; oQ[i] = rdData; oE[i] = echoP; oN[i] = echoN;
    end
    readN = 1'b1; writeN = 1'b1; byteWrN = '1; wrData = '0;
  endtask

  task automatic expectWord(input int i, input logic [DW-1:0] exp, input string tag);
    chk(oV[i] === 1'b1, {tag, " rdOe"}, 32'(oV[i]), 32'd1);
    chk(oQ[i] === exp, {tag, " data"}, 32'(oQ[i]), 32'(exp));
  endtask

  task automatic expectIdle(input int i, input string tag);
    chk(oV[i] === 1'b0, {tag, " rdOe idle"}, 32'(oV[i]), 32'd0);
  endtask

  task automatic testReset();
    chk(rdOe === 1'b0, "R11 rdOe", 32'(rdOe), 32'd0);
    chk(echoP === 1'b1 && echoN === 1'b0, "R11 echo", {30'd0, echoP, echoN}, 32'd2);
    chk(kPhase === 1'b0, "R11 kPhase", 32'(kPhase), 32'd0);
  endtask

  // write, then two back-to-back reads (aligned and misaligned base)
  task automatic testBasic();
    logic [DW-1:0] w [4] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
    clearSeq();
    cmdW[0] = 1'b1; sA[0] = 6'd8;
    for (int k = 0; k < 4; k++) begin sD[2+k] = w[k]; sM[2+k] = '0; end
    cmdR[4] = 1'b1; sA[4] = 6'd8;
    cmdR[8] = 1'b1; sA[8] = 6'd11;
    runSeq(16);
    expectIdle(6, "R2 not before n+3");
    for (int k = 0; k < 4; k++) begin
      expectWord(7 + k, w[k], "R1 R6 R2 aligned burst");
      expectWord(11 + k, w[k], "R1 R4 misaligned base continuous");
    end
    expectIdle(15, "R5 release after last word");
    for (int i = 1; i < 16; i++) begin
      chk(oN[i] === ~oE[i], "R10 echo complement", {30'd0, oE[i], oN[i]}, {30'd0, oE[i], ~oE[i]});
      chk(oE[i] !== oE[i-1], "R10 echo toggle", 32'(oE[i]), 32'(~oE[i-1]));
    end
    chk(oE[7] === 1'b1 && oE[9] === 1'b1, "R10 echo high on words 0/2",
        {30'd0, oE[7], oE[9]}, 32'd3);
  endtask

  task automatic testByteMask();
    logic [DW-1:0] e [4] = '{16'hAA55, 16'h55AA, 16'hAAAA, 16'h5555};
    logic [N_BYTES-1:0] m [4] = '{2'b10, 2'b01, 2'b11, 2'b00};
    clearSeq();
    cmdW[0] = 1'b1; sA[0] = 6'd16;
    for (int k = 0; k < 4; k++) begin sD[2+k] = 16'hAAAA; sM[2+k] = '0; end
    cmdW[4] = 1'b1; sA[4] = 6'd16;
    for (int k = 0; k < 4; k++) begin sD[6+k] = 16'h5555; sM[6+k] = m[k]; end
    cmdR[8] = 1'b1; sA[8] = 6'd16;
    runSeq(16);
    for (int k = 0; k < 4; k++) expectWord(11 + k, e[k], "R7 byte lanes");
  endtask

  task automatic testIgnored();
    logic [DW-1:0] w [4] = '{16'h0C01, 16'h0C02, 16'h0C03, 16'h0C04};
    clearSeq();
    cmdW[0] = 1'b1; sA[0] = 6'd24;
    for (int k = 0; k < 4; k++) begin sD[2+k] = w[k]; sM[2+k] = '0; end
    cmdW[2] = 1'b1; sA[2] = 6'd28;   // ignored write
    cmdR[4] = 1'b1; sA[4] = 6'd24;
    cmdR[6] = 1'b1; sA[6] = 6'd28;   // ignored read
    cmdR[10] = 1'b1; sA[10] = 6'd28;
    runSeq(17);
    for (int k = 0; k < 4; k++) expectWord(7 + k, w[k], "R3 first burst intact");
    expectIdle(11, "R3 R5 ignored read gives no beats");
    expectIdle(12, "R3 R5 ignored read gives no beats");
    for (int k = 0; k < 4; k++) expectWord(13 + k, '0, "R3 ignored write left array");
  endtask

  task automatic testCollision();
    clearSeq();
    cmdR[0] = 1'b1; cmdW[0] = 1'b1; sA[0] = 6'd32;
    for (int k = 0; k < 4; k++) begin sD[2+k] = 16'hBEEF; sM[2+k] = '0; end
    cmdR[4] = 1'b1; sA[4] = 6'd32;
    runSeq(12);
    for (int k = 0; k < 4; k++) begin
      expectWord(3 + k, '0, "R8 read wins");
      expectWord(7 + k, '0, "R8 write dropped");
    end
  endtask

  task automatic testForward();
    logic [DW-1:0] w [4] = '{16'hF0F1, 16'hF2F3, 16'hF4F5, 16'hF6F7};
    clearSeq();
    cmdW[0] = 1'b1; sA[0] = 6'd40;
    for (int k = 0; k < 4; k++) begin sD[2+k] = w[k]; sM[2+k] = '0; end
    cmdR[2] = 1'b1; sA[2] = 6'd40;
    runSeq(10);
    for (int k = 0; k < 4; k++) expectWord(5 + k, w[k], "R9 read during write burst");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBasic();
    testByteMask();
    testIgnored();
    testCollision();
    testForward();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule